// File: doc/BRIEF.md
# Configuration Frame Write Sequencer

This block pushes configuration frames that already sit in a local frame RAM back into a 32-bit device configuration port. A caller supplies a frame address and a frame count, then pulses start with the write operation code. The sequencer first sends a fixed burst of setup words. These are a synchronisation word, a command that selects configuration write, the frame address, an optional CRC-bypass write, and the data-register headers carrying the total word count. It then streams the frame words, one per clock.

The frame buffer holds the dummy frame at offsets 1 to 41, with a spare word at offset 0, and the data frames from offset 42 upward. The sequencer reorders this buffer as it streams. It sends the data frames first and then returns to offset 1 for the trailing dummy frame. After the frames it sends a desynchronise command and drops the port enable. It declares completion only when the port's status byte is seen to move from 0xDF to 0x9F. If that change does not arrive within a programmable number of cycles, it raises an error instead.

The frame RAM has one cycle of read latency. The address output therefore always leads the port data by one cycle, so the stream has no gaps.

Top module: `cfg_frame_writer`

## Requirements
- R1: An operation is accepted only when start_i is high while idle, op_sel_i equals 3'b010 and frame_cnt_i lies in 1..MAX_FRAMES. Any other code or count causes no port activity and leaves done_o and err_o unchanged.
- R2: When idle, port_en_o and port_wr_o are both low. port_wr_o (1 = write) rises at least one cycle before port_en_o rises and stays high while port_en_o is high.
- R3: The setup words are sent in this order: 0xAA995566, 0x20000000, 0x30008001, 0x00000001, 0x30002001, the frame address, then (CRC bypass on, default) 0x30000001 and 0x0000DEFC, then 0x30004000 and 0x50000000 ORed with 41*(N+1).
- R4: Directly after the setup words, the contents of RAM addresses 42 through 42+41*N-1 are sent in ascending order, one word per enabled cycle, with no idle cycle in between.
- R5: Directly after the last data word, the contents of RAM addresses 1 through 41 (the dummy frame) are sent in ascending order.
- R6: The content of RAM address 0 is never sent to the port.
- R7: After the dummy frame, the words 0x30008001, 0x0000000D, 0x20000000 and 0x20000000 are sent. port_en_o is then low until the next operation.
- R8: done_o rises on the cycle after port_status_i has been sampled as 0xDF and then 0x9F on consecutive edges, after the tail words. It stays high until the next accepted start, which clears it.
- R9: If the status change is not seen within timeout_lim_i cycles after the tail, err_o is raised in cycle timeout_lim_i+1 of the wait and done_o stays low. The next accepted start clears err_o.
- R10: A start pulse during an operation is ignored, and the stream in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request |
| op_sel_i | input | 3 | Operation code; 3'b010 selects frame write |
| frame_addr_i | input | 32 | Address of the first frame, sent in the setup words |
| frame_cnt_i | input | CNT_W | Number of data frames N |
| timeout_lim_i | input | TO_W | Wait limit for the status acknowledge, in cycles |
| ram_addr_o | output | ADDR_W | Frame RAM read address, one cycle ahead of the data |
| ram_data_i | input | 32 | Frame RAM read data |
| port_data_o | output | 32 | Word to the configuration port |
| port_en_o | output | 1 | Port enable, active high |
| port_wr_o | output | 1 | Port direction, 1 = write |
| port_status_i | input | 8 | Status byte from the port |
| done_o | output | 1 | Operation completed and acknowledged |
| err_o | output | 1 | Acknowledge timed out |

## Verification
The write is swept over every frame count from one to the maximum. A RAM model returns a word that encodes its own address, so every captured port word shows exactly which offset it came from. This separates a correct data-then-dummy order from an off-by-one at the address jump, from a stray read of offset 0, and from a one-cycle misalignment caused by the RAM latency. A run with a second start pulse in mid-stream and a run against a port that never acknowledges test the busy-lockout and timeout paths. Starts with every other operation code and with out-of-range counts are checked to leave the port silent and the done flag untouched.

// File: rtl/cfw_pkg.sv
`timescale 1ns/1ps
package cfw_pkg;
   typedef enum logic [2:0] {S_IDLE, S_ARM, S_SETUP, S_STREAM, S_TAIL, S_WAIT} cfw_state_e;

   localparam logic [2:0]  OP_WRITE  = 3'b010;
   localparam int          TAIL_N    = 4;

   localparam logic [31:0] W_SYNC    = 32'hAA99_5566;
   localparam logic [31:0] W_NOOP    = 32'h2000_0000;
   localparam logic [31:0] H_CMD     = 32'h3000_8001;
   localparam logic [31:0] C_WCFG    = 32'h0000_0001;
   localparam logic [31:0] H_FAR     = 32'h3000_2001;
   localparam logic [31:0] H_CRC     = 32'h3000_0001;
   localparam logic [31:0] C_CRCBYP  = 32'h0000_DEFC;
   localparam logic [31:0] H_FDRI1   = 32'h3000_4000;
   localparam logic [31:0] H_FDRI2   = 32'h5000_0000;
   localparam logic [31:0] C_DESYNC  = 32'h0000_000D;

   localparam logic [7:0]  ST_BUSY   = 8'hDF;
   localparam logic [7:0]  ST_QUIET  = 8'h9F;
endpackage

// File: rtl/cfw_cmd_rom.sv
`timescale 1ns/1ps
module cfw_cmd_rom
   import cfw_pkg::*;
#(
   parameter bit CRC_BYPASS = 1'b1,
   parameter int IDX_W      = 4,
   parameter int LEN_W      = 8
) (
   input  logic             tail_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [31:0]      far_i,
   input  logic [LEN_W-1:0] len_i,
   output logic [31:0]      word_o,
   output logic [IDX_W-1:0] last_o
);
   localparam int SETUP_N = CRC_BYPASS ? 10 : 8;

   initial begin
      assert (SETUP_N <= 2**IDX_W) else $error("IDX_W too small for setup list");
      assert (LEN_W <= 27) else $error("word count field overflows");
   end

   logic [31:0] setup_w;
   logic [31:0] tail_w;

   generate
      if (CRC_BYPASS) begin : g_crc_bypass
         always_comb begin
            case (int'(idx_i))
               0:       setup_w = W_SYNC;
               1:       setup_w = W_NOOP;
               2:       setup_w = H_CMD;
               3:       setup_w = C_WCFG;
               4:       setup_w = H_FAR;
               5:       setup_w = far_i;
               6:       setup_w = H_CRC;
               7:       setup_w = C_CRCBYP;
               8:       setup_w = H_FDRI1;
               9:       setup_w = H_FDRI2 | 32'(len_i);
               default: setup_w = W_NOOP;
            endcase
         end
      end else begin : g_crc_check
         always_comb begin
            case (int'(idx_i))
               0:       setup_w = W_SYNC;
               1:       setup_w = W_NOOP;
               2:       setup_w = H_CMD;
               3:       setup_w = C_WCFG;
               4:       setup_w = H_FAR;
               5:       setup_w = far_i;
               6:       setup_w = H_FDRI1;
               7:       setup_w = H_FDRI2 | 32'(len_i);
               default: setup_w = W_NOOP;
            endcase
         end
      end
   endgenerate

   always_comb begin
      case (int'(idx_i))
         0:       tail_w = H_CMD;
         1:       tail_w = C_DESYNC;
         default: tail_w = W_NOOP;
      endcase
   end

   assign word_o = tail_i ? tail_w : setup_w;
   assign last_o = tail_i ? IDX_W'(TAIL_N - 1) : IDX_W'(SETUP_N - 1);
endmodule

// File: rtl/cfw_addr_gen.sv
`timescale 1ns/1ps
module cfw_addr_gen #(
   parameter int ADDR_W      = 9,
   parameter int LEN_W       = 8,
   parameter int FRAME_WORDS = 41
) (
   input  logic [LEN_W-1:0]  ptr_i,
   input  logic [LEN_W-1:0]  dlen_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int DATA_BASE = FRAME_WORDS + 1;

   logic [ADDR_W-1:0] p;
   logic [ADDR_W-1:0] d;

   assign p = ADDR_W'(ptr_i);
   assign d = ADDR_W'(dlen_i);

   // data frames first from DATA_BASE, then the dummy frame from offset 1
   assign addr_o = (ptr_i < dlen_i) ? p + ADDR_W'(DATA_BASE)
                                    : p - d + ADDR_W'(1);
endmodule

// File: rtl/cfw_ack_mon.sv
`timescale 1ns/1ps
module cfw_ack_mon
   import cfw_pkg::*;
#(
   parameter int TO_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm_i,
   input  logic [7:0]      status_i,
   input  logic [TO_W-1:0] limit_i,
   output logic            ack_o,
   output logic            tmo_o
);
   logic [7:0]      st_q;
   logic [TO_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_QUIET;
         cnt_q <= '0;
      end else begin
         st_q <= status_i;
         if (!arm_i)
            cnt_q <= '0;
         else if (cnt_q != '1)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ack_o = arm_i && (st_q == ST_BUSY) && (status_i == ST_QUIET);
   assign tmo_o = arm_i && !ack_o && (cnt_q >= limit_i);

   // R9
   tmo_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tmo_o && limit_i != '0) |-> $past(arm_i));
endmodule

// File: rtl/cfg_frame_writer.sv
`timescale 1ns/1ps
module cfg_frame_writer
   import cfw_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int MAX_FRAMES  = 4,
   parameter int FRAME_WORDS = 41,
   parameter int TO_W        = 8,
   parameter bit CRC_BYPASS  = 1'b1,
   localparam int CNT_W      = $clog2(MAX_FRAMES + 1),
   localparam int LEN_W      = $clog2(FRAME_WORDS * (MAX_FRAMES + 1) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [2:0]        op_sel_i,
   input  logic [31:0]       frame_addr_i,
   input  logic [CNT_W-1:0]  frame_cnt_i,
   input  logic [TO_W-1:0]   timeout_lim_i,
   output logic [ADDR_W-1:0] ram_addr_o,
   input  logic [31:0]       ram_data_i,
   output logic [31:0]       port_data_o,
   output logic              port_en_o,
   output logic              port_wr_o,
   input  logic [7:0]        port_status_i,
   output logic              done_o,
   output logic              err_o
);
   localparam int IDX_W = 4;

   initial begin
      assert (MAX_FRAMES >= 1) else $error("MAX_FRAMES must be at least 1");
      assert (FRAME_WORDS >= 2) else $error("FRAME_WORDS too small");
      assert (FRAME_WORDS * (MAX_FRAMES + 2) + 1 <= 2**ADDR_W)
         else $error("frame RAM address range too small");
      assert (ADDR_W >= LEN_W) else $error("ADDR_W narrower than word counter");
   end

   cfw_state_e       state_q;
   logic [IDX_W-1:0] idx_q;
   logic [LEN_W-1:0] s_q, dlen_q, len_q;
   logic [31:0]      far_q;
   logic             done_q, err_q;

   logic             go, in_tail, ack, tmo;
   logic [31:0]      rom_w;
   logic [IDX_W-1:0] rom_last;
   logic [LEN_W-1:0] ptr;

   assign go = (state_q == S_IDLE) && start_i && (op_sel_i == OP_WRITE)
            && (frame_cnt_i != '0) && (frame_cnt_i <= CNT_W'(MAX_FRAMES));
   assign in_tail = (state_q == S_TAIL);

   cfw_cmd_rom #(.CRC_BYPASS(CRC_BYPASS), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_rom (
      .tail_i (in_tail),
      .idx_i  (idx_q),
      .far_i  (far_q),
      .len_i  (len_q),
      .word_o (rom_w),
      .last_o (rom_last)
   );

   // address leads the port by one cycle to cover the RAM read latency
   assign ptr = (state_q == S_STREAM) ? s_q + LEN_W'(1) : '0;

   cfw_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .FRAME_WORDS(FRAME_WORDS)) u_addr (
      .ptr_i  (ptr),
      .dlen_i (dlen_q),
      .addr_o (ram_addr_o)
   );

   cfw_ack_mon #(.TO_W(TO_W)) u_ack (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (state_q == S_WAIT),
      .status_i (port_status_i),
      .limit_i  (timeout_lim_i),
      .ack_o    (ack),
      .tmo_o    (tmo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         idx_q   <= '0;
         s_q     <= '0;
         dlen_q  <= '0;
         len_q   <= '0;
         far_q   <= '0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            S_IDLE: if (go) begin
               state_q <= S_ARM;
               far_q   <= frame_addr_i;
               dlen_q  <= LEN_W'(frame_cnt_i * FRAME_WORDS);
               len_q   <= LEN_W'((frame_cnt_i + 1) * FRAME_WORDS);
               done_q  <= 1'b0;
               err_q   <= 1'b0;
            end
            S_ARM: begin
               state_q <= S_SETUP;
               idx_q   <= '0;
            end
            S_SETUP: begin
               if (idx_q == rom_last) begin
                  state_q <= S_STREAM;
                  s_q     <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            S_STREAM: begin
               if (s_q == len_q - LEN_W'(1)) begin
                  state_q <= S_TAIL;
                  idx_q   <= '0;
               end else begin
                  s_q <= s_q + 1'b1;
               end
            end
            S_TAIL: begin
               if (idx_q == rom_last) state_q <= S_WAIT;
               else                   idx_q   <= idx_q + 1'b1;
            end
            S_WAIT: begin
               if (ack) begin
                  state_q <= S_IDLE;
                  done_q  <= 1'b1;
               end else if (tmo) begin
                  state_q <= S_IDLE;
                  err_q   <= 1'b1;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign port_en_o   = (state_q == S_SETUP) || (state_q == S_STREAM) || in_tail;
   assign port_wr_o   = (state_q != S_IDLE);
   assign port_data_o = (state_q == S_STREAM) ? ram_data_i
                      : port_en_o ? rom_w : '0;
   assign done_o      = done_q;
   assign err_o       = err_q;

   // R2
   dir_before_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_en_o) |-> $past(port_wr_o));
   // R2
   dir_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_en_o |-> port_wr_o);
   // R6
   no_spare_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_STREAM && s_q != len_q - LEN_W'(1)) |-> (ram_addr_o != '0));
   // R7
   quiet_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_WAIT) |-> !port_en_o);
   // R8
   done_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(port_status_i) == ST_QUIET && $past(port_status_i, 2) == ST_BUSY));
   // R9
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));
endmodule

// File: tb/sim_cfg_frame_writer.sv
`timescale 1ns/1ps
module sim_cfg_frame_writer;
   localparam int AW = 9;
   localparam int MAXF = 4;
   localparam int FW = 41;
   localparam int SETUP_N = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'b000;
   logic [31:0] far = '0;
   logic [2:0]  cnt = '0;
   logic [7:0]  tlim = 8'd40;
   logic [AW-1:0] ram_addr;
   logic [31:0] ram_q = '0;
   logic [31:0] pdata;
   logic        pen, pwr, done, err;
   logic [7:0]  status = 8'h9F;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cfg_frame_writer #(.ADDR_W(AW), .MAX_FRAMES(MAXF), .FRAME_WORDS(FW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .op_sel_i(op),
      .frame_addr_i(far), .frame_cnt_i(cnt), .timeout_lim_i(tlim),
      .ram_addr_o(ram_addr), .ram_data_i(ram_q), .port_data_o(pdata),
      .port_en_o(pen), .port_wr_o(pwr), .port_status_i(status),
      .done_o(done), .err_o(err));

   // frame RAM model: one cycle latency, each word encodes its address
   always @(posedge clk) ram_q <= 32'h5A00_0000 | 32'(ram_addr);

   // port model and capture, all at the falling edge
   logic [31:0] cap [0:511];
   int  cap_n = 0, cyc = 0, ack_cnt = 0;
   int  des_k = -1, done_k = -1, off_k = -1, err_k = -1, viol = 0;
   bit  noack = 1'b0, rec = 1'b0, pen_prev = 1'b0, pwr_prev = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (ack_cnt > 0) begin
         ack_cnt--;
         if (ack_cnt == 0 && !noack) status = 8'h9F;
      end
      if (pen && !pwr) viol++;
      if (pen && !pen_prev && !pwr_prev) viol++;
      if (!pen && !pwr && rst_n && (cap_n == 0) && pen_prev) viol++;
      if (pen) begin
         if (cap_n < 512) cap[cap_n] = pdata;
         cap_n++;
         if (pdata == 32'hAA99_5566) status = 8'hDF;
         if (pdata == 32'h0000_000D) begin ack_cnt = 6; des_k = cyc; end
      end else if (cap_n > 0 && off_k < 0) begin
         off_k = cyc;
      end
      if (rec && done && done_k < 0) done_k = cyc;
      if (rec && err && err_k < 0) err_k = cyc;
      pen_prev = pen;
      pwr_prev = pwr;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] expw(input int i, input int n, input logic [31:0] fa);
      int dl = FW * n;
      int tot = FW * (n + 1);
      if (i < SETUP_N) begin
         case (i)
            0: return 32'hAA99_5566;
            1: return 32'h2000_0000;
            2: return 32'h3000_8001;
            3: return 32'h0000_0001;
            4: return 32'h3000_2001;
            5: return fa;
            6: return 32'h3000_0001;
            7: return 32'h0000_DEFC;
            8: return 32'h3000_4000;
            default: return 32'h5000_0000 | 32'(tot);
         endcase
      end else if (i < SETUP_N + dl) begin
         return 32'h5A00_0000 | 32'(FW + 1 + i - SETUP_N);
      end else if (i < SETUP_N + tot) begin
         return 32'h5A00_0000 | 32'(1 + i - SETUP_N - dl);
      end else begin
         case (i - SETUP_N - tot)
            0: return 32'h3000_8001;
            1: return 32'h0000_000D;
            default: return 32'h2000_0000;
         endcase
      end
   endfunction

   function automatic string tagof(input int i, input int n);
      if (i < SETUP_N) return "R3 setup word";
      if (i < SETUP_N + FW * n) return "R4 data word";
      if (i < SETUP_N + FW * (n + 1)) return "R5 dummy word";
      return "R7 tail word";
   endfunction

   task automatic launch(input int n, input logic [31:0] fa, input bit poke);
      cap_n = 0; des_k = -1; done_k = -1; off_k = -1; err_k = -1; viol = 0;
      @(negedge clk);
      start = 1'b1; op = 3'b010; cnt = 3'(n); far = fa;
      @(negedge clk);
      start = 1'b0;
      rec = 1'b1;
      if (poke) begin
         repeat (30) @(negedge clk);
         start = 1'b1; cnt = 3'd1; far = 32'hFFFF_FFFF;
         @(negedge clk);
         start = 1'b0;
      end
      for (int k = 0; k < 3000; k++) begin
         @(negedge clk);
         if (done || err) break;
      end
      @(negedge clk);
      rec = 1'b0;
   endtask

   task automatic check_stream(input int n, input logic [31:0] fa, input string note);
      int len = SETUP_N + FW * (n + 1) + 4;
      bit saw0 = 1'b0;
      bit mism = 1'b0;
      chk(cap_n == len, {"R4 word count ", note}, cap_n, len);
      for (int i = 0; i < len && i < cap_n; i++) begin
         if (cap[i] !== expw(i, n, fa)) begin
            if (!mism) chk(1'b0, {tagof(i, n), " ", note}, cap[i], expw(i, n, fa));
            mism = 1'b1;
         end
         if (i >= SETUP_N && cap[i] == 32'h5A00_0000) saw0 = 1'b1;
      end
      if (!mism) chk(1'b1, "R4", 0, 0);
      chk(!saw0, {"R6 offset 0 sent ", note}, saw0, 0);
      chk(viol == 0, {"R2 direction/enable order ", note}, viol, 0);
      chk(done && !err, {"R8 done after ack ", note}, {done, err}, 2'b10);
      chk(done_k - des_k == 7, {"R8 done latency from desync ", note}, done_k - des_k, 7);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk(!pen && !pwr, "R2 idle port", {pen, pwr}, 0);
      chk(!done && !err, "R8 reset flags", {done, err}, 0);

      // sweep frame counts
      for (int n = 1; n <= MAXF; n++) begin
         launch(n, 32'h0010_0000 + 32'(n * 36), 1'b0);
         check_stream(n, 32'h0010_0000 + 32'(n * 36), $sformatf("n=%0d", n));
      end

      // R1: wrong operation codes are ignored
      for (int c = 0; c < 8; c++) begin
         if (c == 2) continue;
         cap_n = 0;
         @(negedge clk);
         start = 1'b1; op = 3'(c); cnt = 3'd2;
         @(negedge clk);
         start = 1'b0;
         repeat (6) @(negedge clk);
         chk(cap_n == 0 && !pwr, $sformatf("R1 op=%0d port silent", c), cap_n, 0);
         chk(done && !err, $sformatf("R1 op=%0d flags kept", c), {done, err}, 2'b10);
      end
      // R1: out of range counts are ignored
      foreach (cnt_bad[j]) ;
      for (int b = 0; b < 2; b++) begin
         cap_n = 0;
         @(negedge clk);
         start = 1'b1; op = 3'b010; cnt = (b == 0) ? 3'd0 : 3'(MAXF + 1);
         @(negedge clk);
         start = 1'b0;
         repeat (6) @(negedge clk);
         chk(cap_n == 0 && done, $sformatf("R1 count=%0d ignored", cnt), cap_n, 0);
      end

      // R10: second start during the stream is ignored
      launch(3, 32'h00AB_CDE0, 1'b1);
      check_stream(3, 32'h00AB_CDE0, "R10 busy start");

      // R9: port never acknowledges
      noack = 1'b1; tlim = 8'd20;
      launch(2, 32'h0000_1234, 1'b0);
      chk(err && !done, "R9 timeout flags", {done, err}, 2'b01);
      chk(err_k - off_k == 21, "R9 timeout cycle", err_k - off_k, 21);
      noack = 1'b0; tlim = 8'd40;

      // R9: next accepted start clears the error
      launch(1, 32'h0000_0042, 1'b0);
      chk(!err, "R9 error cleared", err, 0);
      check_stream(1, 32'h0000_0042, "after timeout");

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   int cnt_bad [1];

   initial begin : watchdog
      #(5.0 * 150000);
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule